// File: doc/BRIEF.md
# Prioritised Cache Request Serializer

This block sits in front of the tag pipeline of a unified second-level cache. Three sources can present requests in the same cycle. Bus snoops arrive on one port. The first-level data cache presents one load and up to two stores. The first-level instruction cache presents one fetch. Every port has a valid/ready handshake and a one-entry holding register. The block sends at most one held request per cycle to a single issue port, and that port carries a tag that names the source slot.

Priority is fixed by class:

1. snoops first,
2. data-cache traffic second (the load ahead of the stores, and the older store ahead of the younger),
3. instruction fetches last.

A fetch counter stops the fetch from being starved. Once a held fetch has been passed over for a set number of cycles in a row, it goes ahead of every other request.

The issue port is driven straight from the holding registers. A request taken at a clock edge can therefore issue in the very next cycle. A port's ready signal is the inverse of its registered occupancy. A port can therefore hand over a new request one cycle after its previous one has issued.

Top module: `l2_req_serializer`

## Requirements
- R1: After reset all five ready outputs are high and `iss_valid` is low.
- R2: At most one request issues per cycle. Each accepted request issues exactly once, and only while held. No held request is lost.
- R3: A request is taken at a clock edge where its valid and ready are both high. From the next cycle the port's ready is low, and the slot holds the address unchanged until the request issues. Ready goes high again in the cycle after the issue.
- R4: A request taken at an edge is eligible in the following cycle. If no higher-priority request is held, it issues in that cycle.
- R5: With no forced fetch, a held snoop always issues ahead of data-cache and fetch requests. A held data-cache request always issues ahead of a held fetch.
- R6: A held load issues before held stores. Between two held stores, the one taken earlier issues first. When both stores are taken at the same edge, store port 0 counts as older.
- R7: A snoop taken while lower-priority requests are pending issues in the cycle right after it was taken, ahead of them, unless a fetch is forced in that cycle.
- R8: A held fetch issues after at most `STARVE_LIM` (default 8) consecutive cycles of being passed over. In the next cycle it issues ahead of every other request, including a snoop.
- R9: `iss_src` encodes the issuing slot as follows, and `iss_addr` equals the address that was taken for that slot:

  | Slot | `iss_src` |
  |---|---|
  | snoop | 0 |
  | load | 1 |
  | store port 0 | 2 |
  | store port 1 | 3 |
  | fetch | 4 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snoop request present |
| snp_ready | output | 1 | Snoop slot free |
| snp_addr | input | ADDR_W | Snoop address |
| ld_valid | input | 1 | Data-cache load present |
| ld_ready | output | 1 | Load slot free |
| ld_addr | input | ADDR_W | Load address |
| st0_valid | input | 1 | Data-cache store, port 0 |
| st0_ready | output | 1 | Store slot 0 free |
| st0_addr | input | ADDR_W | Store port 0 address |
| st1_valid | input | 1 | Data-cache store, port 1 |
| st1_ready | output | 1 | Store slot 1 free |
| st1_addr | input | ADDR_W | Store port 1 address |
| if_valid | input | 1 | Instruction fetch present |
| if_ready | output | 1 | Fetch slot free |
| if_addr | input | ADDR_W | Fetch address |
| iss_valid | output | 1 | A request issues this cycle |
| iss_src | output | 3 | Source slot of the issued request (R9 encoding) |
| iss_addr | output | ADDR_W | Address of the issued request |

## Verification
The bench fills all five slots in one cycle and checks the order snoop, load, store 0, store 1, fetch. A design with a wrong class order or a store tie-break that favours port 1 shows up here. It then takes store port 1 a cycle before store port 0 and expects port 1 to issue first. A design that breaks store ties by port number instead of age fails this case.

A snoop that arrives behind a backlog must issue the cycle after it is taken. A design that queues it behind older lower-class work misses that cycle. The bench also saturates snoop and data traffic to starve a fetch. It expects the fetch to issue exactly at its ninth held cycle, so a counter limit that is off by one, or one that never overrides a snoop, is caught. A random phase then compares every cycle against the behavioural model and checks that issues balance acceptances.

// File: rtl/l2s_pkg.sv
package l2s_pkg;
    localparam int NSLOT   = 5;
    localparam int SL_SNP  = 0;
    localparam int SL_LD   = 1;
    localparam int SL_ST0  = 2;
    localparam int SL_ST1  = 3;
    localparam int SL_IF   = 4;
    localparam int SRC_W   = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_SNOOP  = 3'd0,
        SRC_LOAD   = 3'd1,
        SRC_STORE0 = 3'd2,
        SRC_STORE1 = 3'd3,
        SRC_FETCH  = 3'd4
    } src_e;
endpackage

// File: rtl/l2s_slot.sv
module l2s_slot #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic              ready,
    output logic              occ,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic              occ;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (pop) begin
            slot_d.occ = 1'b0;
        end
        if (push_valid && !slot_q.occ) begin
            slot_d.occ  = 1'b1;
            slot_d.addr = push_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign ready = !slot_q.occ;
    assign occ   = slot_q.occ;
    assign addr  = slot_q.addr;

    // R3: a held request stays held with a stable address until popped
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ && !pop) |=> (occ && $stable(addr)));

    // R2: only an occupied slot can be issued
    assert_pop_occ_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> occ);

    // R3: a push lands in the slot on the next cycle
    assert_push_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && ready) |=> (occ && addr == $past(push_addr)));
endmodule

// File: rtl/l2s_arbiter.sv
module l2s_arbiter
    import l2s_pkg::*;
#(
    parameter int STARVE_LIM = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] occ,
    input  logic             fill_st0,
    input  logic             fill_st1,
    output logic [NSLOT-1:0] grant
);
    localparam int CNT_W = $clog2(STARVE_LIM + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(STARVE_LIM);

    typedef struct packed {
        logic             st1_older;
        logic [CNT_W-1:0] cnt;
    } arb_t;

    arb_t arb_d, arb_q;
    logic force_if;

    always_comb begin
        force_if = occ[SL_IF] && (arb_q.cnt >= LIM);
        grant    = '0;
        if (force_if) begin
            grant[SL_IF] = 1'b1;
        end else if (occ[SL_SNP]) begin
            grant[SL_SNP] = 1'b1;
        end else if (occ[SL_LD]) begin
            grant[SL_LD] = 1'b1;
        end else if (occ[SL_ST0] && occ[SL_ST1]) begin
            if (arb_q.st1_older) grant[SL_ST1] = 1'b1;
            else                 grant[SL_ST0] = 1'b1;
        end else if (occ[SL_ST0]) begin
            grant[SL_ST0] = 1'b1;
        end else if (occ[SL_ST1]) begin
            grant[SL_ST1] = 1'b1;
        end else if (occ[SL_IF]) begin
            grant[SL_IF] = 1'b1;
        end

        arb_d = arb_q;
        if (fill_st0 && fill_st1) begin
            arb_d.st1_older = 1'b0;
        end else if (fill_st0 && occ[SL_ST1]) begin
            arb_d.st1_older = 1'b1;
        end else if (fill_st1 && occ[SL_ST0]) begin
            arb_d.st1_older = 1'b0;
        end

        if (!occ[SL_IF] || grant[SL_IF]) begin
            arb_d.cnt = '0;
        end else if (arb_q.cnt < LIM) begin
            arb_d.cnt = arb_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q <= '0;
        end else begin
            arb_q <= arb_d;
        end
    end

    // R2: one issue per cycle at most
    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R4: any held request means something issues
    assert_work_conserving_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|occ) |-> (|grant));

    // R5 / R7: snoop wins unless a fetch is forced
    assert_snoop_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (occ[SL_SNP] && !(occ[SL_IF] && arb_q.cnt == LIM)) |-> grant[SL_SNP]);

    // R6: load ahead of stores when no snoop or forced fetch
    assert_load_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (occ[SL_LD] && !occ[SL_SNP] && !force_if) |-> grant[SL_LD]);

    // R6: store 0 taken while store 1 stays held must not pass store 1
    assert_store_age_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_st0 && !fill_st1 && occ[SL_ST1] && !grant[SL_ST1]) |=> !grant[SL_ST0]);

    // R8: fetch counter bounded and honoured
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arb_q.cnt <= LIM);
    assert_starve_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ[SL_IF] && arb_q.cnt == LIM) |-> grant[SL_IF]);
endmodule

// File: rtl/l2_req_serializer.sv
module l2_req_serializer
    import l2s_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int STARVE_LIM = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    output logic              snp_ready,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st0_valid,
    output logic              st0_ready,
    input  logic [ADDR_W-1:0] st0_addr,
    input  logic              st1_valid,
    output logic              st1_ready,
    input  logic [ADDR_W-1:0] st1_addr,
    input  logic              if_valid,
    output logic              if_ready,
    input  logic [ADDR_W-1:0] if_addr,
    output logic              iss_valid,
    output logic [SRC_W-1:0]  iss_src,
    output logic [ADDR_W-1:0] iss_addr
);
    logic [NSLOT-1:0]  in_vld;
    logic [ADDR_W-1:0] in_addr   [NSLOT];
    logic [NSLOT-1:0]  slot_rdy;
    logic [NSLOT-1:0]  slot_occ;
    logic [ADDR_W-1:0] slot_addr [NSLOT];
    logic [NSLOT-1:0]  grant;

    assign in_vld = {if_valid, st1_valid, st0_valid, ld_valid, snp_valid};
    assign in_addr[SL_SNP] = snp_addr;
    assign in_addr[SL_LD]  = ld_addr;
    assign in_addr[SL_ST0] = st0_addr;
    assign in_addr[SL_ST1] = st1_addr;
    assign in_addr[SL_IF]  = if_addr;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        l2s_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (in_vld[i]),
            .push_addr  (in_addr[i]),
            .pop        (grant[i]),
            .ready      (slot_rdy[i]),
            .occ        (slot_occ[i]),
            .addr       (slot_addr[i])
        );
    end

    l2s_arbiter #(.STARVE_LIM(STARVE_LIM)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .occ      (slot_occ),
        .fill_st0 (st0_valid && slot_rdy[SL_ST0]),
        .fill_st1 (st1_valid && slot_rdy[SL_ST1]),
        .grant    (grant)
    );

    assign snp_ready = slot_rdy[SL_SNP];
    assign ld_ready  = slot_rdy[SL_LD];
    assign st0_ready = slot_rdy[SL_ST0];
    assign st1_ready = slot_rdy[SL_ST1];
    assign if_ready  = slot_rdy[SL_IF];

    always_comb begin
        iss_valid = 1'b0;
        iss_src   = '0;
        iss_addr  = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (grant[i]) begin
                iss_valid = 1'b1;
                iss_src   = SRC_W'(i);
                iss_addr  = slot_addr[i];
            end
        end
    end

    // R9: the tag always names a real slot
    assert_src_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_src <= SRC_W'(SL_IF)));

    // R3: a port whose request was just taken is not ready next cycle
    assert_ready_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |=> !ld_ready);

    // R1: outputs quiet in the cycle after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!iss_valid && snp_ready && ld_ready && st0_ready && st1_ready && if_ready));
endmodule

// File: tb/l2_req_serializer_tb.sv
module l2_req_serializer_tb;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snp_valid = 0, ld_valid = 0, st0_valid = 0, st1_valid = 0, if_valid = 0;
    logic [AW-1:0] snp_addr = '0, ld_addr = '0, st0_addr = '0, st1_addr = '0, if_addr = '0;
    logic snp_ready, ld_ready, st0_ready, st1_ready, if_ready;
    logic iss_valid;
    logic [2:0] iss_src;
    logic [AW-1:0] iss_addr;

    always #4 clk = ~clk;

    l2_req_serializer #(.ADDR_W(AW), .STARVE_LIM(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_addr(snp_addr),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
        .st0_valid(st0_valid), .st0_ready(st0_ready), .st0_addr(st0_addr),
        .st1_valid(st1_valid), .st1_ready(st1_ready), .st1_addr(st1_addr),
        .if_valid(if_valid), .if_ready(if_ready), .if_addr(if_addr),
        .iss_valid(iss_valid), .iss_src(iss_src), .iss_addr(iss_addr)
    );

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // behavioural model
    bit m_occ [5];
    logic [AW-1:0] m_addr [5];
    int m_seq [5];
    int seqctr = 0;
    int m_wait = 0;
    int cyc = 0;
    int if_acc_cyc = 0;
    int snp_acc_cyc = 0;
    int n_acc = 0;
    int n_iss = 0;
    int log_q [$];
    int max_if_wait = 0;

    function automatic int pick();
        if (m_occ[4] && m_wait >= 8) return 4;
        if (m_occ[0]) return 0;
        if (m_occ[1]) return 1;
        if (m_occ[2] && m_occ[3]) return (m_seq[2] < m_seq[3]) ? 2 : 3;
        if (m_occ[2]) return 2;
        if (m_occ[3]) return 3;
        if (m_occ[4]) return 4;
        return -1;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s cycle %0d act=%0h exp=%0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic compare();
        int g;
        logic [4:0] rdy;
        g = pick();
        rdy = {if_ready, st1_ready, st0_ready, ld_ready, snp_ready};
        chk(tag, "iss_valid", longint'(iss_valid), longint'(g >= 0));
        if (g >= 0 && iss_valid) begin
            chk(tag, "iss_src", longint'(iss_src), longint'(g));
            chk(tag, "iss_addr", longint'(iss_addr), longint'(m_addr[g]));
        end
        for (int i = 0; i < 5; i++)
            chk(tag, "ready", longint'(rdy[i]), longint'(!m_occ[i]));
        if (iss_valid) begin
            n_iss++;
            log_q.push_back(int'(iss_src));
            if (iss_src == 3'd4 && (cyc - if_acc_cyc) > max_if_wait)
                max_if_wait = cyc - if_acc_cyc;
            if (iss_src == 3'd0 && tag == "R7")
                chk("R7", "snoop latency", longint'(cyc - snp_acc_cyc), 1);
        end
    endtask

    task automatic model_step();
        int g;
        bit acc [5];
        logic [4:0] v;
        logic [AW-1:0] a [5];
        v = {if_valid, st1_valid, st0_valid, ld_valid, snp_valid};
        a[0] = snp_addr; a[1] = ld_addr; a[2] = st0_addr; a[3] = st1_addr; a[4] = if_addr;
        g = pick();
        for (int i = 0; i < 5; i++) acc[i] = v[i] && !m_occ[i];
        if (m_occ[4] && g != 4) m_wait++; else m_wait = 0;
        if (g >= 0) m_occ[g] = 0;
        for (int i = 0; i < 5; i++) begin
            if (acc[i]) begin
                m_occ[i] = 1; m_addr[i] = a[i]; m_seq[i] = seqctr; seqctr++; n_acc++;
                if (i == 4) if_acc_cyc = cyc;
                if (i == 0) snp_acc_cyc = cyc;
            end
        end
    endtask

    task automatic cycle(input bit s, input bit l, input bit a, input bit b, input bit f);
        snp_valid = s; ld_valid = l; st0_valid = a; st1_valid = b; if_valid = f;
        snp_addr = $urandom; ld_addr = $urandom; st0_addr = $urandom;
        st1_addr = $urandom; if_addr = $urandom;
        model_step();
        cyc++;
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cycle(0, 0, 0, 0, 0);
    endtask

    task automatic chk_log(input string req, input int exp [$]);
        chk(req, "issue count", longint'(log_q.size()), longint'(exp.size()));
        for (int k = 0; k < exp.size() && k < log_q.size(); k++)
            chk(req, "issue order", longint'(log_q[k]), longint'(exp[k]));
    endtask

    initial begin
        logic [AW-1:0] la;
        for (int i = 0; i < 5; i++) begin m_occ[i] = 0; m_addr[i] = '0; m_seq[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        compare();
        chk("R1", "reset iss_valid", longint'(iss_valid), 0);
        chk("R1", "reset readies", longint'({snp_ready, ld_ready, st0_ready, st1_ready, if_ready}), 5'h1f);

        // R4 / R9 / R3: single load
        tag = "R4";
        cycle(0, 1, 0, 0, 0);
        la = m_addr[1];
        chk("R4", "load issues next cycle", longint'(iss_valid), 1);
        chk("R9", "load src code 1", longint'(iss_src), 1);
        chk("R9", "load addr", longint'(iss_addr), longint'(la));
        chk("R3", "ld_ready low while held", longint'(ld_ready), 0);
        cycle(0, 0, 0, 0, 0);
        chk("R3", "ld_ready back after issue", longint'(ld_ready), 1);
        cycle(1, 0, 0, 0, 0);
        chk("R9", "snoop src code 0", longint'(iss_src), 0);
        idle(2);

        // R5 / R6: all five together
        tag = "R5";
        log_q.delete();
        cycle(1, 1, 1, 1, 1);
        idle(6);
        chk_log("R5", '{0, 1, 2, 3, 4});

        // R6: store 1 taken before store 0
        tag = "R6";
        log_q.delete();
        cycle(1, 1, 0, 1, 0);
        cycle(0, 0, 1, 0, 0);
        idle(5);
        chk_log("R6", '{0, 1, 3, 2});

        // R7: snoop behind a backlog
        tag = "R7";
        log_q.delete();
        cycle(0, 1, 1, 1, 1);
        cycle(1, 0, 0, 0, 0);
        idle(6);
        chk_log("R7", '{1, 0, 2, 3, 4});

        // R8: fetch starved by saturating traffic
        tag = "R8";
        max_if_wait = 0;
        for (int k = 0; k < 60; k++) cycle(1, 1, 1, 1, 1);
        idle(10);
        chk("R8", "worst fetch wait", longint'(max_if_wait), 9);

        // R2: random traffic
        tag = "R2";
        for (int k = 0; k < 400; k++)
            cycle($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 0, $urandom_range(0, 1) == 0,
                  $urandom_range(0, 1) == 0, $urandom_range(0, 1) == 0);
        idle(12);
        chk("R2", "issued equals accepted", longint'(n_iss), longint'(n_acc));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule